// File: doc/BRIEF.md
# Tick Counter Compare Timer

This block keeps two time counters and three compare registers for a processor core. The cycle tick counter advances once per clock in which `tick_en` is high. The system tick counter is derived from a free-running time base that advances on `stick_en`, minus an offset. Software sets the system tick counter by writing a value, and the block stores that value as an offset from the time base. The top bit of the system tick register is a non-privileged-trap flag. While the flag is set, user-mode reads of the counter fault.

Each compare register holds a disable flag in its top bit and a compare value in the bits below it. A comparator is armed only when its register is written with the disable flag clear and a value strictly ahead of its counter. It then emits one single-cycle match pulse when the counter reaches the value. The tick compare watches the cycle counter. The system compare and the hyperprivileged compare both watch the system counter. The match pulses are meant to feed a soft-interrupt register.

Register access uses a one-request-per-cycle port. `req_valid` has no back-pressure: the port never stalls, so every request is accepted in the cycle it is presented. Its response, with data and a fault code, follows in the next cycle.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, the cycle and system counters read 0, the NPT flag is 1, and every compare register reads with its disable bit (bit CNT_W) set and its compare field at 0.
- R2: `req_sel` encodes the registers as follows: 0 is the cycle counter, 1 the tick compare, 2 the system counter, 3 the system compare and 4 the hyper compare. `rsp_fault` encodes 0 as none, 1 as privileged-opcode, 2 as privileged-action and 3 as illegal. `req_priv` encodes 0 as user, 1 as privileged, and 2 or 3 as hyperprivileged.
- R3: An armed comparator produces exactly one match pulse, one cycle long. The pulse comes one cycle after its counter equals the compare field.
- R4: A compare write whose compare field is equal to or behind the current counter value produces no pulse.
- R5: A compare write with the disable bit set produces no pulse and cancels a pending armed match.
- R6: A user-mode access to any compare register returns fault 1 with read data 0 and leaves the register unchanged.
- R7: Only hyperprivileged mode may write the system counter. A user-mode write returns fault 1 and a privileged-mode write returns fault 2. A write sets the NPT flag from bit CNT_W and the counter from the bits below it.
- R8: A system counter read returns the NPT flag in bit CNT_W and the count below it. If the NPT flag is set, a user-mode read returns fault 2 with read data 0.
- R9: The system counter advances by one for each cycle with `stick_en` high, counting from the last written value. The system and hyper compares match against it.
- R10: A select above 4, or a write to the cycle counter, returns fault 3 and changes nothing.
- R11: Every request gets exactly one response, with `rsp_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Cycle counter advance enable |
| stick_en | input | 1 | System time base advance enable |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select |
| req_priv | input | 2 | Privilege level of the access |
| req_wdata | input | CNT_W+1 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 2 | Fault code |
| rsp_rdata | output | CNT_W+1 | Read data, 0 on fault |
| tick_match | output | 1 | Tick compare match pulse |
| stick_match | output | 1 | System compare match pulse |
| hyper_match | output | 1 | Hyper compare match pulse |

## Verification
A response is due one cycle after its request, so the bench drives a request on a falling edge and reads the response on the next falling edge. A compare written ahead by d counts pulses after d+1 enabled rising edges: d edges bring the counter to the value, and one more registers the pulse. The sweeps hold the counter enables low during register accesses. They then count enabled edges from the falling edge where the enable rises, checking the match output at each falling edge. This pins down both the cycle of the pulse and its absence in every other cycle of the window.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [2:0] {
    SEL_TICK      = 3'd0,
    SEL_TICK_CMP  = 3'd1,
    SEL_STICK     = 3'd2,
    SEL_STICK_CMP = 3'd3,
    SEL_HYPER_CMP = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_OPCODE  = 2'd1,
    FLT_ACTION  = 2'd2,
    FLT_ILLEGAL = 2'd3
  } fault_e;

  localparam int unsigned NUM_CMP = 3;
endpackage

// File: rtl/tcmp_compare.sv
module tcmp_compare #(
  parameter int unsigned W = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W:0]   wr_data,
  input  logic [W-1:0] cnt,
  output logic [W:0]   cfg_o,
  output logic         match_o
);
  logic [W:0] cfg_q;
  logic       armed_q;
  logic       match_q;
  logic       hit;

  assign hit = armed_q && !cfg_q[W] && (cnt == cfg_q[W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= {1'b1, {W{1'b0}}};
      armed_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (wr_en) begin
        cfg_q   <= wr_data;
        armed_q <= !wr_data[W] && (wr_data[W-1:0] > cnt);
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign match_o = match_q;
endmodule

// File: rtl/tcmp_stick.sv
module tcmp_stick #(
  parameter int unsigned W = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         wr_en,
  input  logic [W:0]   wr_data,
  output logic [W-1:0] value_o,
  output logic         npt_o
);
  logic [W-1:0] base_q;
  logic [W-1:0] offset_q;
  logic         npt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      offset_q <= '0;
      npt_q    <= 1'b1;
    end else begin
      if (adv) base_q <= base_q + 1'b1;
      if (wr_en) begin
        offset_q <= base_q - wr_data[W-1:0];
        npt_q    <= wr_data[W];
      end
    end
  end

  assign value_o = base_q - offset_q;
  assign npt_o   = npt_q;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 63
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           stick_en,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [2:0]     req_sel,
  input  logic [1:0]     req_priv,
  input  logic [CNT_W:0] req_wdata,
  output logic           rsp_valid,
  output logic [1:0]     rsp_fault,
  output logic [CNT_W:0] rsp_rdata,
  output logic           tick_match,
  output logic           stick_match,
  output logic           hyper_match
);
  localparam int unsigned DW = CNT_W + 1;

  logic [CNT_W-1:0] tick_q;
  logic [CNT_W-1:0] stick_val;
  logic             npt;
  logic [DW-1:0]    cfg   [NUM_CMP];
  logic [CNT_W-1:0] cmp_cnt [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_wr;
  logic [NUM_CMP-1:0] cmp_hit;
  logic [NUM_CMP-1:0] cfg_dis;
  logic             stick_wr;
  fault_e           fault_d;
  logic [DW-1:0]    rdata_d;
  logic             is_user, is_hyper;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else if (tick_en) tick_q <= tick_q + 1'b1;
  end

  tcmp_stick #(.W(CNT_W)) u_stick (
    .clk(clk), .rst_n(rst_n), .adv(stick_en),
    .wr_en(stick_wr), .wr_data(req_wdata),
    .value_o(stick_val), .npt_o(npt)
  );

  assign cmp_cnt[0] = tick_q;
  assign cmp_cnt[1] = stick_val;
  assign cmp_cnt[2] = stick_val;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tcmp_compare #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr[g]), .wr_data(req_wdata),
      .cnt(cmp_cnt[g]), .cfg_o(cfg[g]), .match_o(cmp_hit[g])
    );
    assign cfg_dis[g] = cfg[g][CNT_W];
  end

  assign is_user  = (req_priv == 2'd0);
  assign is_hyper = req_priv[1];

  always_comb begin
    fault_d  = FLT_NONE;
    rdata_d  = '0;
    cmp_wr   = '0;
    stick_wr = 1'b0;
    if (req_valid) begin
      case (req_sel)
        SEL_TICK: begin
          if (req_write) fault_d = FLT_ILLEGAL;
          else rdata_d = {1'b0, tick_q};
        end
        SEL_STICK: begin
          if (req_write) begin
            if (is_user) fault_d = FLT_OPCODE;
            else if (!is_hyper) fault_d = FLT_ACTION;
            else stick_wr = 1'b1;
          end else if (is_user && npt) begin
            fault_d = FLT_ACTION;
          end else begin
            rdata_d = {npt, stick_val};
          end
        end
        SEL_TICK_CMP, SEL_STICK_CMP, SEL_HYPER_CMP: begin
          if (is_user) fault_d = FLT_OPCODE;
          else if (req_write) begin
            case (req_sel)
              SEL_TICK_CMP:  cmp_wr[0] = 1'b1;
              SEL_STICK_CMP: cmp_wr[1] = 1'b1;
              default:       cmp_wr[2] = 1'b1;
            endcase
          end else begin
            case (req_sel)
              SEL_TICK_CMP:  rdata_d = cfg[0];
              SEL_STICK_CMP: rdata_d = cfg[1];
              default:       rdata_d = cfg[2];
            endcase
          end
        end
        default: fault_d = FLT_ILLEGAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= fault_d;
      rsp_rdata <= rdata_d;
    end
  end

  assign tick_match  = cmp_hit[0];
  assign stick_match = cmp_hit[1];
  assign hyper_match = cmp_hit[2];
endmodule

// File: rtl/tick_cmp_timer_checker.sv
module tick_cmp_timer_checker #(
  parameter int unsigned CNT_W = 63
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [2:0]     req_sel,
  input logic [1:0]     req_priv,
  input logic           rsp_valid,
  input logic [1:0]     rsp_fault,
  input logic [CNT_W:0] rsp_rdata,
  input logic           tick_match,
  input logic           stick_match,
  input logic           hyper_match,
  input logic [2:0]     cfg_dis
);
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_fault_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_rdata == '0));
  p_user_cmp_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd0 &&
     (req_sel == 3'd1 || req_sel == 3'd3 || req_sel == 3'd4)) |=> (rsp_fault == 2'd1));
  p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel > 3'd4) |=> (rsp_fault == 2'd3));
  p_user_stick_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 3'd2 && req_priv == 2'd0) |=> (rsp_fault == 2'd1));
  p_tick_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_match |=> !tick_match);
  p_stick_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stick_match |=> !stick_match);
  p_hyper_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hyper_match |=> !hyper_match);
  p_tick_dis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_match |-> !$past(cfg_dis[0]));
  p_stick_dis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stick_match |-> !$past(cfg_dis[1]));
  p_hyper_dis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hyper_match |-> !$past(cfg_dis[2]));
endmodule

bind tick_cmp_timer tick_cmp_timer_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_sel(req_sel), .req_priv(req_priv), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .tick_match(tick_match),
  .stick_match(stick_match), .hyper_match(hyper_match), .cfg_dis(cfg_dis)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
  localparam int unsigned W = 10;
  localparam int unsigned MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, stick_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_sel = '0;
  logic [1:0] req_priv = '0;
  logic [W:0] req_wdata = '0;
  logic rsp_valid;
  logic [1:0] rsp_fault;
  logic [W:0] rsp_rdata;
  logic tick_match, stick_match, hyper_match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_cmp_timer #(.CNT_W(W)) u_tick_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stick_en(stick_en),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_priv(req_priv), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .tick_match(tick_match),
    .stick_match(stick_match), .hyper_match(hyper_match)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int sel, input int priv, input int wd,
                        output int rd, output int flt);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel[2:0];
    req_priv = priv[1:0]; req_wdata = wd[W:0];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(rsp_valid == 1'b1, "R11 rsp_valid", int'(rsp_valid), 1);
    rd = int'(rsp_rdata); flt = int'(rsp_fault);
  endtask

  function automatic bit pick(int idx);
    case (idx)
      0: pick = tick_match;
      1: pick = stick_match;
      default: pick = hyper_match;
    endcase
  endfunction

  // Arm comparator idx at counter+d with disable bit dis; count pulses over a window.
  task automatic sweep_one(input int idx, input int d, input bit dis, input bit cancel);
    int rd, flt, cur, tgt, first, cnt;
    access(1'b0, (idx == 0) ? 0 : 2, 2, 0, rd, flt);
    cur = rd % MOD;
    tgt = (cur + d + MOD) % MOD;
    access(1'b1, (idx == 0) ? 1 : (idx == 1 ? 3 : 4), 1, (int'(dis) << W) | tgt, rd, flt);
    if (cancel) access(1'b1, (idx == 0) ? 1 : (idx == 1 ? 3 : 4), 2, (1 << W) | tgt, rd, flt);
    first = -1; cnt = 0;
    @(negedge clk);
    if (idx == 0) tick_en = 1'b1; else stick_en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (pick(idx)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    tick_en = 1'b0; stick_en = 1'b0;
    if (d >= 1 && !dis && !cancel) begin
      check(cnt == 1, "R3 pulse count", cnt, 1);
      check(first == d + 1, "R3 pulse cycle", first, d + 1);
    end else if (dis || cancel) begin
      check(cnt == 0, "R5 disabled pulse count", cnt, 0);
    end else begin
      check(cnt == 0, "R4 behind pulse count", cnt, 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd, flt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    access(1'b0, 0, 2, 0, rd, flt);
    check(rd == 0 && flt == 0, "R1 tick reset", rd, 0);
    access(1'b0, 2, 2, 0, rd, flt);
    check(rd == (1 << W), "R1 stick reset npt", rd, 1 << W);
    for (int s = 1; s <= 4; s++) begin
      if (s == 2) continue;
      access(1'b0, s, 1, 0, rd, flt);
      check(rd == (1 << W) && flt == 0, "R1 R2 compare reset", rd, 1 << W);
    end

    // R8 user read with NPT set
    access(1'b0, 2, 0, 0, rd, flt);
    check(flt == 2, "R8 npt user fault", flt, 2);
    check(rd == 0, "R8 npt user data", rd, 0);

    // R6 user access to compares
    for (int s = 1; s <= 4; s++) begin
      if (s == 2) continue;
      access(1'b1, s, 0, 5, rd, flt);
      check(flt == 1, "R6 user write fault", flt, 1);
      access(1'b0, s, 1, 0, rd, flt);
      check(rd == (1 << W), "R6 compare unchanged", rd, 1 << W);
      access(1'b0, s, 0, 0, rd, flt);
      check(flt == 1 && rd == 0, "R6 user read fault", flt, 1);
    end

    // R7 stick write privilege
    access(1'b1, 2, 0, 77, rd, flt);
    check(flt == 1, "R7 user stick write", flt, 1);
    access(1'b1, 2, 1, 77, rd, flt);
    check(flt == 2, "R7 priv stick write", flt, 2);
    access(1'b0, 2, 2, 0, rd, flt);
    check(rd == (1 << W), "R7 stick unchanged", rd, 1 << W);
    access(1'b1, 2, 3, 100, rd, flt);
    check(flt == 0, "R7 hyper stick write", flt, 0);
    access(1'b0, 2, 0, 0, rd, flt);
    check(flt == 0 && rd == 100, "R8 user read npt clear", rd, 100);

    // R9 advance
    @(negedge clk); stick_en = 1'b1;
    repeat (7) @(negedge clk);
    stick_en = 1'b0;
    access(1'b0, 2, 2, 0, rd, flt);
    check(rd == 107, "R9 stick advance", rd, 107);
    access(1'b1, 2, 2, (1 << W) | 200, rd, flt);
    access(1'b0, 2, 1, 0, rd, flt);
    check(rd == ((1 << W) | 200), "R8 read with npt", rd, (1 << W) | 200);

    // R10 illegal
    for (int s = 5; s <= 7; s++) begin
      access(1'b0, s, 2, 0, rd, flt);
      check(flt == 3 && rd == 0, "R10 bad select", flt, 3);
    end
    access(1'b1, 0, 2, 9, rd, flt);
    check(flt == 3, "R10 tick write", flt, 3);

    // advance tick so negative offsets stay behind without wrapping
    @(negedge clk); tick_en = 1'b1;
    repeat (20) @(negedge clk);
    tick_en = 1'b0;
    access(1'b0, 0, 1, 0, rd, flt);
    check(rd == 20, "R1 tick advance", rd, 20);

    // R3 R4 R5 sweeps on all three comparators
    for (int idx = 0; idx < 3; idx++) begin
      for (int d = -3; d <= 9; d++) sweep_one(idx, d, 1'b0, 1'b0);
      for (int d = 1; d <= 4; d++) sweep_one(idx, d, 1'b1, 1'b0);
      for (int d = 2; d <= 5; d++) sweep_one(idx, d, 1'b0, 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule